// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel

This block is one channel of a DMA engine that runs a program of 16-byte command descriptors held in memory. Software sets up the channel through a small register window: a masked control register, a read-only status register, a command pointer, and three condition-select registers. After software sets RUN, the channel reads descriptors over a simple request/response read port. It hands data-moving commands to a device handshake stub. It writes each command's completion word back into the descriptor. Between commands it applies the per-command interrupt, branch and wait conditions.

Commands that move no data (NOP and the two quad commands) are completed by the channel itself. Execution continues through them until a data command or a STOP is reached. After a STOP the channel stays parked until software sets WAKE or clears RUN.

Top module: `desc_dma_channel`

## Requirements
- R1: After reset, the status register and the command pointer read 0, irq is low, and no read, write or device request is raised.
- R2: A write to the control register (offset 0) changes only the status bits selected by its upper half. The new values come from the lower half, and only bits S7..S0 (bits 7:0), WAKE (0x1000), FLUSH (0x2000), PAUSE (0x4000) and RUN (0x8000) can be written. BT (0x0100), ACTIVE (0x0400) and DEAD (0x0800) ignore such writes, and DEAD always reads 0. Writes to the status register (offset 4) leave the status unchanged.
- R3: A write to the command pointer low register (offset 12) is stored only while RUN and ACTIVE are both clear, and is dropped otherwise. A write to offset 8 is not stored (it reads 0), and a nonzero value pulses ptrHiFlag during that write.
- R4: When the channel is started, it sets ACTIVE and reads descriptor words at ptr, ptr+4 and ptr+8. Word 0 holds the request count in bits 15:0, the condition byte in bits 23:16 and the key byte in bits 31:24. Word 1 holds the buffer address and word 2 the branch target.
- R5: The command code is key-byte bits 7:4. Codes 0..3 are data commands: they raise devReq with devCount = request count and devAddr = buffer address, devInput = code bit 1, and wait for devDone. Codes 4, 5 and 6 complete without device traffic. Code 7 is STOP.
- R6: Every command with code below 7 writes the word {status, residual} to ptr+12. The residual is devResidual for data commands and 0 otherwise. A STOP writes nothing: it clears ACTIVE, leaves the pointer on the STOP, and halts.
- R7: Each 2-bit condition (wait = bits 1:0, branch = bits 3:2, interrupt = bits 5:4 of the condition byte) is evaluated against its select register, which holds the mask in bits 23:16 and the value in bits 7:0. Code 0 means never, code 3 means always, code 1 means the test ((S7..S0 & mask) == value) is true, and code 2 means that test is false.
- R8: A met branch condition loads the pointer from the branch target and sets BT. Otherwise the pointer advances by 16 and BT clears.
- R9: A met interrupt condition gives a one-cycle pulse on irq after the writeback.
- R10: While the wait condition is met, the channel holds before fetching the next descriptor, with ACTIVE set. It resumes once software changes S7..S0 so that the condition no longer holds.
- R11: Setting WAKE while stopped restarts the fetch at the current pointer, and the hardware clears WAKE. FLUSH clears one cycle after it is set.
- R12: PAUSE holds the channel before its next fetch with ACTIVE set. Clearing RUN at such a boundary returns the channel to idle with ACTIVE clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| ptrHiFlag | output | 1 | Nonzero write to the unsupported pointer-high register |
| rdReq | output | 1 | Descriptor read request, held until rdValid |
| rdAddr | output | 32 | Descriptor read byte address |
| rdValid | input | 1 | Read data valid |
| rdData | input | 32 | Read data |
| wrReq | output | 1 | Completion-word write request, held until wrAck |
| wrAddr | output | 32 | Completion-word byte address |
| wrData | output | 32 | Completion word {status, residual} |
| wrAck | input | 1 | Write accepted |
| devReq | output | 1 | Device transfer request, held until devDone |
| devAddr | output | 32 | Transfer buffer address |
| devCount | output | 16 | Requested byte count |
| devInput | output | 1 | 1 for device-to-memory, 0 for memory-to-device |
| devDone | input | 1 | Device transfer finished |
| devResidual | input | 16 | Bytes not transferred |
| irq | output | 1 | Interrupt pulse |

## Verification
The embedded assertions watch, on every cycle, that only one of the read, write and device requests is raised at a time, that a pending read keeps its address, and that completion words always land on the last word of a descriptor. They also check that irq never lasts longer than a cycle, that a pointer write during a run is dropped, and that FLUSH clears itself. The bench scenarios are needed for the parts that depend on descriptor content. These are the order of fetches, the condition results under particular select values and S bits, the branch target and BT, the completion word contents, the wait hold and its release, WAKE after STOP, and the effect of PAUSE and of clearing RUN.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 16;
  localparam int REG_AW   = 5;
  localparam int DESC_B   = 16;
  localparam int STAT_W   = 16;

  // status bit positions
  localparam int B_BT     = 8;
  localparam int B_ACTIVE = 10;
  localparam int B_DEAD   = 11;
  localparam int B_WAKE   = 12;
  localparam int B_FLUSH  = 13;
  localparam int B_PAUSE  = 14;
  localparam int B_RUN    = 15;
  localparam logic [STAT_W-1:0] SW_BITS = 16'hF0FF;

  localparam logic [3:0] CMD_STOP = 4'd7;
  localparam logic [3:0] CMD_LAST_DATA = 4'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_NEXT, ST_FETCH, ST_DECODE, ST_XFER,
    ST_WBACK, ST_POST, ST_WAITC, ST_STOPPED
  } chanState_t;

  typedef struct packed {
    logic       ldWord;
    logic [1:0] wordIdx;
    logic       ldResid;
    logic       zeroResid;
    logic       setActive;
    logic       clrActive;
    logic       takeBranch;
    logic       advance;
    logic       clrWake;
  } dmaStrobe_t;

  function automatic logic condMet(input logic [1:0] code, input logic [7:0] sBits,
                                   input logic [15:0] sel);
    logic hit;
    hit = ((sBits & sel[15:8]) == sel[7:0]);
    case (code)
      2'd0:    condMet = 1'b0;
      2'd1:    condMet = hit;
      2'd2:    condMet = !hit;
      default: condMet = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/desc_dma_dp.sv
module desc_dma_dp
  import desc_dma_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic                ptrHiFlag,
  input  dmaStrobe_t          strobe,
  input  logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   devAddr,
  output logic [CNT_W-1:0]    devCount,
  output logic                devInput,
  input  logic [CNT_W-1:0]    devResidual,
  output logic [3:0]          cmdCode,
  output logic                runBit,
  output logic                activeBit,
  output logic                pauseBit,
  output logic                wakeBit,
  output logic                waitHit,
  output logic                brHit,
  output logic                intHit
);
  localparam logic [REG_AW-1:0] OFF_CTL  = 5'd0;
  localparam logic [REG_AW-1:0] OFF_STAT = 5'd4;
  localparam logic [REG_AW-1:0] OFF_PHI  = 5'd8;
  localparam logic [REG_AW-1:0] OFF_PLO  = 5'd12;
  localparam logic [REG_AW-1:0] OFF_ISEL = 5'd16;
  localparam logic [REG_AW-1:0] OFF_BSEL = 5'd20;
  localparam logic [REG_AW-1:0] OFF_WSEL = 5'd24;

  logic [STAT_W-1:0] statusQ, statusD;
  logic [DATA_W-1:0] cmdPtr, bufAddr, brTarget;
  logic [CNT_W-1:0]  reqCnt, resid;
  logic [7:0]        condByte, keyByte;
  logic [15:0]       intSel, brSel, waitSel;
  logic              ctlWr, ptrLoWr;
  logic [STAT_W-1:0] wrMask;

  assign ctlWr   = regWr && regAddr == OFF_CTL;
  assign ptrLoWr = regWr && regAddr == OFF_PLO;
  assign wrMask  = regWdata[31:16] & SW_BITS;
  assign ptrHiFlag = regWr && regAddr == OFF_PHI && regWdata != '0;

  always_comb begin
    statusD = statusQ;
    if (strobe.setActive)  statusD[B_ACTIVE] = 1'b1;
    if (strobe.clrActive)  statusD[B_ACTIVE] = 1'b0;
    if (strobe.takeBranch) statusD[B_BT] = 1'b1;
    if (strobe.advance)    statusD[B_BT] = 1'b0;
    if (strobe.clrWake)    statusD[B_WAKE] = 1'b0;
    if (statusQ[B_FLUSH])  statusD[B_FLUSH] = 1'b0;
    if (ctlWr) statusD = (statusD & ~wrMask) | (regWdata[15:0] & wrMask);
    statusD[B_DEAD] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0; cmdPtr <= '0; bufAddr <= '0; brTarget <= '0;
      reqCnt <= '0; resid <= '0; condByte <= '0; keyByte <= '0;
      intSel <= '0; brSel <= '0; waitSel <= '0;
    end else begin
      statusQ <= statusD;
      if (ptrLoWr && !statusQ[B_RUN] && !statusQ[B_ACTIVE]) cmdPtr <= regWdata;
      else if (strobe.takeBranch) cmdPtr <= brTarget;
      else if (strobe.advance)    cmdPtr <= cmdPtr + DATA_W'(DESC_B);
      if (regWr && regAddr == OFF_ISEL) intSel  <= {regWdata[23:16], regWdata[7:0]};
      if (regWr && regAddr == OFF_BSEL) brSel   <= {regWdata[23:16], regWdata[7:0]};
      if (regWr && regAddr == OFF_WSEL) waitSel <= {regWdata[23:16], regWdata[7:0]};
      if (strobe.ldWord) begin
        case (strobe.wordIdx)
          2'd0: {keyByte, condByte, reqCnt} <= rdData;
          2'd1: bufAddr  <= rdData;
          default: brTarget <= rdData;
        endcase
      end
      if (strobe.ldResid)   resid <= devResidual;
      if (strobe.zeroResid) resid <= '0;
    end
  end

  always_comb begin
    case (regAddr)
      OFF_CTL, OFF_STAT: regRdata = {16'h0, statusQ};
      OFF_PLO:  regRdata = cmdPtr;
      OFF_ISEL: regRdata = {8'h0, intSel[15:8], 8'h0, intSel[7:0]};
      OFF_BSEL: regRdata = {8'h0, brSel[15:8], 8'h0, brSel[7:0]};
      OFF_WSEL: regRdata = {8'h0, waitSel[15:8], 8'h0, waitSel[7:0]};
      default:  regRdata = '0;
    endcase
  end

  assign rdAddr   = cmdPtr + {28'h0, strobe.wordIdx, 2'b00};
  assign wrAddr   = cmdPtr + DATA_W'(DESC_B - 4);
  assign wrData   = {statusQ, resid};
  assign devAddr  = bufAddr;
  assign devCount = reqCnt;
  assign cmdCode  = keyByte[7:4];
  assign devInput = keyByte[5];
  assign runBit   = statusQ[B_RUN];
  assign activeBit = statusQ[B_ACTIVE];
  assign pauseBit = statusQ[B_PAUSE];
  assign wakeBit  = statusQ[B_WAKE];
  assign waitHit  = condMet(condByte[1:0], statusQ[7:0], waitSel);
  assign brHit    = condMet(condByte[3:2], statusQ[7:0], brSel);
  assign intHit   = condMet(condByte[5:4], statusQ[7:0], intSel);

  AST_PTR_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    ptrLoWr && (statusQ[B_RUN] || statusQ[B_ACTIVE]) && !strobe.takeBranch && !strobe.advance
    |=> $stable(cmdPtr)); // R3
  AST_WB_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldResid |=> wrAddr[3:0] == 4'hC); // R6
  AST_FLUSH_CLR: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[B_FLUSH] && !(ctlWr && regWdata[16+B_FLUSH] && regWdata[B_FLUSH])
    |=> !statusQ[B_FLUSH]); // R11
endmodule

// File: rtl/desc_dma_ctrl.sv
module desc_dma_ctrl
  import desc_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  cmdCode,
  input  logic        runBit,
  input  logic        activeBit,
  input  logic        pauseBit,
  input  logic        wakeBit,
  input  logic        waitHit,
  input  logic        brHit,
  input  logic        intHit,
  input  logic        rdValid,
  input  logic        wrAck,
  input  logic        devDone,
  output logic        rdReq,
  output logic        wrReq,
  output logic        devReq,
  output logic        irq,
  output dmaStrobe_t  strobe
);
  chanState_t state, stateNxt;
  logic [1:0] idx, idxNxt;

  always_comb begin
    stateNxt = state;
    idxNxt   = idx;
    strobe   = '0;
    strobe.wordIdx = idx;
    if (wakeBit && state != ST_IDLE) strobe.clrWake = 1'b1;
    case (state)
      ST_IDLE: if (runBit) begin strobe.setActive = 1'b1; stateNxt = ST_NEXT; end
      ST_NEXT: begin
        if (!runBit) begin strobe.clrActive = 1'b1; stateNxt = ST_IDLE; end
        else if (!pauseBit) begin idxNxt = '0; stateNxt = ST_FETCH; end
      end
      ST_FETCH: if (rdValid) begin
        strobe.ldWord = 1'b1;
        if (idx == 2'd2) stateNxt = ST_DECODE;
        else idxNxt = idx + 2'd1;
      end
      ST_DECODE: begin
        if (cmdCode <= CMD_LAST_DATA) stateNxt = ST_XFER;
        else if (cmdCode == CMD_STOP) begin strobe.clrActive = 1'b1; stateNxt = ST_STOPPED; end
        else begin strobe.zeroResid = 1'b1; stateNxt = ST_WBACK; end
      end
      ST_XFER: if (devDone) begin strobe.ldResid = 1'b1; stateNxt = ST_WBACK; end
      ST_WBACK: if (wrAck) stateNxt = ST_POST;
      ST_POST: begin
        if (brHit) strobe.takeBranch = 1'b1;
        else strobe.advance = 1'b1;
        stateNxt = ST_WAITC;
      end
      ST_WAITC: begin
        if (!runBit) begin strobe.clrActive = 1'b1; stateNxt = ST_IDLE; end
        else if (!waitHit) stateNxt = ST_NEXT;
      end
      ST_STOPPED: begin
        if (!runBit) stateNxt = ST_IDLE;
        else if (wakeBit) begin strobe.setActive = 1'b1; stateNxt = ST_NEXT; end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; idx <= '0; irq <= 1'b0;
    end else begin
      state <= stateNxt;
      idx   <= idxNxt;
      irq   <= (state == ST_POST) && intHit;
    end
  end

  assign rdReq  = state == ST_FETCH;
  assign wrReq  = state == ST_WBACK;
  assign devReq = state == ST_XFER;

  AST_ONE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdReq, wrReq, devReq})); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdValid |=> rdReq && $stable(strobe.wordIdx)); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R9
  AST_DEV_DATA_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    devReq |-> cmdCode <= CMD_LAST_DATA && activeBit); // R5
endmodule

// File: rtl/desc_dma_channel.sv
module desc_dma_channel
  import desc_dma_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic                ptrHiFlag,
  output logic                rdReq,
  output logic [DATA_W-1:0]   rdAddr,
  input  logic                rdValid,
  input  logic [DATA_W-1:0]   rdData,
  output logic                wrReq,
  output logic [DATA_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  input  logic                wrAck,
  output logic                devReq,
  output logic [DATA_W-1:0]   devAddr,
  output logic [CNT_W-1:0]    devCount,
  output logic                devInput,
  input  logic                devDone,
  input  logic [CNT_W-1:0]    devResidual,
  output logic                irq
);
  dmaStrobe_t strobe;
  logic [3:0] cmdCode;
  logic runBit, activeBit, pauseBit, wakeBit, waitHit, brHit, intHit;

  desc_dma_dp uDp (
    .clk, .rstN, .regWr, .regAddr, .regWdata, .regRdata, .ptrHiFlag,
    .strobe, .rdData, .rdAddr, .wrAddr, .wrData, .devAddr, .devCount,
    .devInput, .devResidual, .cmdCode, .runBit, .activeBit, .pauseBit,
    .wakeBit, .waitHit, .brHit, .intHit
  );

  desc_dma_ctrl uCtrl (
    .clk, .rstN, .cmdCode, .runBit, .activeBit, .pauseBit, .wakeBit,
    .waitHit, .brHit, .intHit, .rdValid, .wrAck, .devDone,
    .rdReq, .wrReq, .devReq, .irq, .strobe
  );
endmodule

// File: tb/sim_desc_dma_channel.sv
module sim_desc_dma_channel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic ptrHiFlag, rdReq, wrReq, devReq, devInput, irq;
  logic [31:0] rdAddr, wrAddr, wrData, devAddr;
  logic [15:0] devCount;
  logic rdValid = 1'b0, wrAck = 1'b0, devDone = 1'b0;
  logic [31:0] rdData = '0;
  logic [15:0] devResidual = 16'd5;

  logic [31:0] mem [64];
  logic [31:0] wbMem [64];
  int checks = 0, errors = 0, cycles = 0;
  int irqCount = 0, rdCount = 0;
  logic [15:0] seenCnt = '0;
  logic [31:0] seenAddr = '0;
  logic seenIn = 1'b1;
  logic hiSeen = 1'b0;

  always #4 clk = ~clk;

  desc_dma_channel u0 (
    .clk, .rstN, .regWr, .regAddr, .regWdata, .regRdata, .ptrHiFlag,
    .rdReq, .rdAddr, .rdValid, .rdData, .wrReq, .wrAddr, .wrData, .wrAck,
    .devReq, .devAddr, .devCount, .devInput, .devDone, .devResidual, .irq
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    rdValid <= rdReq && !rdValid;
    rdData  <= mem[rdAddr[7:2]];
    wrAck   <= wrReq && !wrAck;
    if (wrReq && !wrAck) wbMem[wrAddr[7:2]] <= wrData;
    devDone <= devReq && !devDone;
    if (devReq && !devDone) begin seenCnt <= devCount; seenAddr <= devAddr; seenIn <= devInput; end
    if (irq) irqCount <= irqCount + 1;
    if (rdReq) rdCount <= rdCount + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    #1 hiSeen = ptrHiFlag;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); regAddr = a; #1 v = regRdata;
  endtask

  task automatic waitHalt();
    logic [31:0] s;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 500; i++) begin
      regRead(5'd4, s);
      if (!s[10]) break;
    end
  endtask

  function automatic logic [31:0] w0(input logic [3:0] code, input logic [1:0] ic,
                                     input logic [1:0] bc, input logic [1:0] wc, input logic [15:0] cnt);
    return {code, 4'h0, 2'b00, ic, bc, wc, cnt};
  endfunction

  task automatic putDesc(input int at, input logic [31:0] word0, input logic [31:0] a, input logic [31:0] arg);
    mem[at/4] = word0; mem[at/4+1] = a; mem[at/4+2] = arg; mem[at/4+3] = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    regRead(5'd4, v);  check("R1 status", v, 32'h0);
    regRead(5'd12, v); check("R1 pointer", v, 32'h0);
    check("R1 outputs", {29'h0, rdReq | wrReq | devReq, irq, ptrHiFlag}, 32'h0);
  endtask

  task automatic t_ctrlMask();
    logic [31:0] v;
    regWrite(5'd0, 32'h00FF_00A5); regRead(5'd4, v); check("R2 masked S bits", v, 32'h00A5);
    regWrite(5'd0, 32'h0F00_0F00); regRead(5'd4, v); check("R2 hw bits not writable", v, 32'h00A5);
    regWrite(5'd4, 32'hFFFF_FFFF); regRead(5'd4, v); check("R2 status write ignored", v, 32'h00A5);
    regWrite(5'd0, 32'h2000_2000); regRead(5'd4, v); check("R11 flush self-clear", v, 32'h00A5);
  endtask

  task automatic t_pointer();
    logic [31:0] v;
    regWrite(5'd8, 32'h0000_0001); check("R3 hi flag", {31'h0, hiSeen}, 32'h1);
    regWrite(5'd8, 32'h0); check("R3 hi zero no flag", {31'h0, hiSeen}, 32'h0);
    regRead(5'd8, v); check("R3 hi not stored", v, 32'h0);
    regWrite(5'd12, 32'h40); regRead(5'd12, v); check("R3 ptr lo stored", v, 32'h40);
  endtask

  task automatic t_runChain();
    logic [31:0] v;
    int irq0;
    putDesc(32'h40, w0(4'd6, 2'd3, 2'd0, 2'd0, 16'h0), 32'h0, 32'h0);
    putDesc(32'h50, w0(4'd0, 2'd0, 2'd0, 2'd0, 16'h0020), 32'h1234, 32'h0);
    putDesc(32'h60, w0(4'd7, 2'd0, 2'd0, 2'd0, 16'h0), 32'h0, 32'h0);
    irq0 = irqCount;
    regWrite(5'd0, 32'h8000_8000);
    waitHalt();
    check("R6 NOP writeback", wbMem[32'h4C/4], 32'h84A5_0000);
    check("R6 data writeback residual", wbMem[32'h5C/4], 32'h84A5_0005);
    check("R5 device count", {16'h0, seenCnt}, 32'h20);
    check("R5 device address", seenAddr, 32'h1234);
    check("R5 device direction", {31'h0, seenIn}, 32'h0);
    check("R9 irq always", irqCount - irq0, 32'd1);
    regRead(5'd4, v);  check("R6 stop clears active", v, 32'h80A5);
    regRead(5'd12, v); check("R4 pointer on stop", v, 32'h60);
    regWrite(5'd12, 32'h100); regRead(5'd12, v); check("R3 ptr lo blocked by RUN", v, 32'h60);
    putDesc(32'h60, w0(4'd6, 2'd0, 2'd0, 2'd0, 16'h0), 32'h0, 32'h0);
    putDesc(32'h70, w0(4'd7, 2'd0, 2'd0, 2'd0, 16'h0), 32'h0, 32'h0);
    regWrite(5'd0, 32'h1000_1000);
    waitHalt();
    check("R11 wake resumes", wbMem[32'h6C/4], 32'h84A5_0000);
    regRead(5'd12, v); check("R11 wake pointer", v, 32'h70);
    regRead(5'd4, v);  check("R11 wake cleared", v, 32'h80A5);
  endtask

  task automatic t_branch();
    logic [31:0] v;
    int irq0;
    regWrite(5'd0, 32'h8000_0000);
    regWrite(5'd12, 32'h80);
    regWrite(5'd20, 32'h000F_0005);
    regWrite(5'd16, 32'h00F0_00A0);
    putDesc(32'h80, w0(4'd6, 2'd2, 2'd1, 2'd0, 16'h0), 32'h0, 32'hC0);
    putDesc(32'hC0, w0(4'd7, 2'd0, 2'd0, 2'd0, 16'h0), 32'h0, 32'h0);
    irq0 = irqCount;
    regWrite(5'd0, 32'h8000_8000);
    waitHalt();
    regRead(5'd12, v); check("R8 branch taken target", v, 32'hC0);
    regRead(5'd4, v);  check("R8 BT set", v, 32'h81A5);
    check("R7 interrupt if-false not met", irqCount - irq0, 32'd0);
    regWrite(5'd0, 32'h8000_0000);
    regWrite(5'd12, 32'h90);
    putDesc(32'h90, w0(4'd6, 2'd1, 2'd2, 2'd0, 16'h0), 32'h0, 32'hC0);
    putDesc(32'hA0, w0(4'd7, 2'd0, 2'd0, 2'd0, 16'h0), 32'h0, 32'h0);
    irq0 = irqCount;
    regWrite(5'd0, 32'h8000_8000);
    waitHalt();
    regRead(5'd12, v); check("R8 branch not taken advances", v, 32'hA0);
    regRead(5'd4, v);  check("R8 BT cleared", v, 32'h80A5);
    check("R7 interrupt if-true met", irqCount - irq0, 32'd1);
  endtask

  task automatic t_wait();
    logic [31:0] v;
    regWrite(5'd0, 32'h8000_0000);
    regWrite(5'd12, 32'hD0);
    regWrite(5'd24, 32'h0001_0001);
    putDesc(32'hD0, w0(4'd6, 2'd0, 2'd0, 2'd1, 16'h0), 32'h0, 32'h0);
    putDesc(32'hE0, w0(4'd7, 2'd0, 2'd0, 2'd0, 16'h0), 32'h0, 32'h0);
    regWrite(5'd0, 32'h8000_8000);
    repeat (40) @(negedge clk);
    regRead(5'd4, v);  check("R10 wait holds active", v, 32'h84A5);
    regRead(5'd12, v); check("R10 pointer advanced before wait", v, 32'hE0);
    regWrite(5'd0, 32'h0001_0000);
    waitHalt();
    regRead(5'd4, v);  check("R10 wait released", v, 32'h80A4);
  endtask

  task automatic t_pause();
    logic [31:0] v;
    int rd0;
    regWrite(5'd0, 32'h8000_0000);
    regWrite(5'd12, 32'hF0);
    putDesc(32'hF0, w0(4'd7, 2'd0, 2'd0, 2'd0, 16'h0), 32'h0, 32'h0);
    rd0 = rdCount;
    regWrite(5'd0, 32'hC000_C000);
    repeat (20) @(negedge clk);
    check("R12 pause no fetch", rdCount - rd0, 32'd0);
    regRead(5'd4, v); check("R12 pause active", v, 32'hC4A4);
    regWrite(5'd0, 32'h8000_0000);
    repeat (3) @(negedge clk);
    regRead(5'd4, v); check("R12 run clear idles", v, 32'h40A4);
    regWrite(5'd0, 32'h4000_0000);
    regWrite(5'd0, 32'h8000_8000);
    waitHalt();
    check("R12 resumed fetch", {31'h0, rdCount > rd0}, 32'h1);
    regRead(5'd4, v); check("R12 stop after resume", v, 32'h80A4);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ctrlMask();
    t_pointer();
    t_runChain();
    t_branch();
    t_wait();
    t_pause();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule